// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave is holding stuck by keeping SDA low. When a recovery is requested, it first tells the byte controller to answer the byte in progress with NACK. It then clocks the bus through a fixed train of nine SCL pulses on an open-drain clock output, each pulse pulling SCL low first and then releasing it. Last, it asks the controller for a STOP condition. A single-cycle done pulse closes each attempt, and the unit then returns to idle with SCL released.

The length of each low phase and each high phase is a tick count of the system clock, so a 20 µs half-period can be matched at any clock rate. The count is captured when an attempt starts. The unit grants at most a fixed number of attempts. A further request is refused and raises a timeout flag. An external bus-free indication clears both the attempt count and the timeout. Sensing SDA, detecting a busy bus and shaping the STOP waveform are left to neighbouring logic.

Top module: `i2c_bus_clear`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, all outputs (`scl_low_o`, `nack_force_o`, `stop_req_o`, `done_o`, `busy_o`, `timeout_o`) are 0.
- R2: A `start_i` pulse accepted in idle makes `busy_o` and `nack_force_o` 1 from the next cycle on. SCL then stays released (`scl_low_o`=0) for H cycles, where H is `half_ticks_i`, and a value of 0 is treated as 1.
- R3: After that NACK lead-in come exactly 9 pulses. Each pulse is H cycles with `scl_low_o`=1 followed by H cycles with `scl_low_o`=0, the low phase first.
- R4: In the cycle after the ninth high phase ends, `stop_req_o` is 1 for exactly one cycle. `nack_force_o` stays 1 from the lead-in through that cycle.
- R5: `done_o` is 1 for exactly the one cycle after `stop_req_o`, with `nack_force_o` and `scl_low_o` at 0. In the following cycle `busy_o` is 0.
- R6: `half_ticks_i` is captured when a start is accepted. Changing it during an attempt does not alter that attempt's timing.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. It does not restart the attempt and does not count as an attempt.
- R8: At most MAX_TRIES (default 2) attempts are granted. A `start_i` pulse in idle once that many have been granted starts nothing, leaves `busy_o` at 0, and sets `timeout_o` to 1 from the next cycle.
- R9: A `bus_free_i` pulse clears `timeout_o` in the next cycle and resets the attempt count, so a later start is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Recovery request strobe |
| bus_free_i | input | 1 | Bus seen free; clears attempt count and timeout |
| half_ticks_i | input | TICK_W | Clock ticks per SCL half-period (0 acts as 1) |
| scl_low_o | output | 1 | 1 = pull the open-drain SCL line low |
| nack_force_o | output | 1 | Force the controller to answer with NACK |
| stop_req_o | output | 1 | Request a STOP condition (one cycle) |
| done_o | output | 1 | Attempt finished (one-cycle pulse) |
| busy_o | output | 1 | An attempt is in progress |
| timeout_o | output | 1 | Attempt limit reached and a further request was refused |

## Verification
A wrong phase state shows at once at the ports, in the same cycle that the state register holds it. SCL is then driven while NACK is not forced, or STOP is requested in the middle of a pulse. A tick timer that miscounts stretches or shortens a phase, and a per-cycle comparison catches that at the first wrong cycle of the lead-in. A pulse counter that is off by one moves `stop_req_o` by 2H cycles. A miscounted attempt shows only at the next request, as an early or missing `timeout_o`.

// File: rtl/i2c_bus_clear_pkg.sv
// Shared types for the bus-clear recovery sequencer.
package i2c_bus_clear_pkg;
    // Recovery phases in the order they are visited.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_NACK = 3'd1,
        PH_LOW  = 3'd2,
        PH_HIGH = 3'd3,
        PH_STOP = 3'd4,
        PH_DONE = 3'd5
    } rec_phase_t;
endpackage

// File: rtl/bc_tick_timer.sv
// Half-period tick timer. It captures the tick count on load, with 0 taken
// as 1. While run is high it counts, and it flags expiry on the last tick of
// each phase. Assumes load is raised only while run is low.
module bc_tick_timer #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W-1:0] load_val,
    input  logic              run,
    output logic              expire
);
    logic [TICK_W-1:0] h_q;
    logic [TICK_W-1:0] cnt_q;

    // Capture the half-period length at the start of an attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            h_q <= TICK_W'(1);
        else if (load)
            h_q <= (load_val == '0) ? TICK_W'(1) : load_val;
    end

    // Count ticks within the current phase; restart at each expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + TICK_W'(1);
    end

    // Flag the final tick of a phase.
    always_comb expire = run && (cnt_q == h_q - TICK_W'(1));
endmodule

// File: rtl/bc_pulse_counter.sv
// Counts completed SCL pulses and flags the last one of the train.
// Assumes step is raised once per finished high phase.
module bc_pulse_counter #(
    parameter int NUM_PULSES = 9,
    localparam int CW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    logic [CW-1:0] cnt_q;

    // Advance on each finished pulse, clear between attempts.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + CW'(1);
    end

    // The pulse now running is the final one.
    always_comb last = (cnt_q == CW'(NUM_PULSES - 1));
endmodule

// File: rtl/bc_attempt_limiter.sv
// Limits recovery attempts. It grants a request while fewer than MAX_TRIES
// attempts have run and sets a sticky timeout when it refuses one.
// bus_free clears both the count and the timeout, and takes priority.
module bc_attempt_limiter #(
    parameter int MAX_TRIES = 2,
    localparam int AW = $clog2(MAX_TRIES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic request,
    input  logic bus_free,
    output logic grant,
    output logic timeout
);
    logic [AW-1:0] tries_q;

    // A request is granted only while attempts remain.
    always_comb grant = request && (tries_q < AW'(MAX_TRIES));

    // Track granted attempts.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_free)
            tries_q <= '0;
        else if (grant)
            tries_q <= tries_q + AW'(1);
    end

    // Hold the timeout after a refused request until the bus is free.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_free)
            timeout <= 1'b0;
        else if (request && !grant)
            timeout <= 1'b1;
    end
endmodule

// File: rtl/i2c_bus_clear.sv
// I2C bus-clear recovery sequencer. It runs NACK lead-in, then NUM_PULSES
// SCL pulses (low first), then a STOP request and a done pulse. All outputs
// decode the registered phase. Assumes the SCL pad is open-drain, with
// scl_low_o enabling the pull-down.
module i2c_bus_clear
    import i2c_bus_clear_pkg::*;
#(
    parameter int TICK_W     = 16,
    parameter int NUM_PULSES = 9,
    parameter int MAX_TRIES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bus_free_i,
    input  logic [TICK_W-1:0] half_ticks_i,
    output logic              scl_low_o,
    output logic              nack_force_o,
    output logic              stop_req_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              timeout_o
);
    rec_phase_t phase_q, phase_d;
    logic       req, grant, tick_run, expire, last_pulse, pulse_step;

    // Only requests seen in idle are offered to the limiter.
    always_comb req = start_i && (phase_q == PH_IDLE);

    // Timer runs through the lead-in and both pulse phases.
    always_comb tick_run = (phase_q == PH_NACK) || (phase_q == PH_LOW) ||
                           (phase_q == PH_HIGH);

    // One pulse completes at the end of each high phase.
    always_comb pulse_step = (phase_q == PH_HIGH) && expire;

    bc_attempt_limiter #(.MAX_TRIES(MAX_TRIES)) u_limit (
        .clk(clk), .rst_n(rst_n), .request(req), .bus_free(bus_free_i),
        .grant(grant), .timeout(timeout_o)
    );

    bc_tick_timer #(.TICK_W(TICK_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(grant), .load_val(half_ticks_i),
        .run(tick_run), .expire(expire)
    );

    bc_pulse_counter #(.NUM_PULSES(NUM_PULSES)) u_pulses (
        .clk(clk), .rst_n(rst_n), .clr(phase_q == PH_IDLE),
        .step(pulse_step), .last(last_pulse)
    );

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (grant)  phase_d = PH_NACK;
            PH_NACK: if (expire) phase_d = PH_LOW;
            PH_LOW:  if (expire) phase_d = PH_HIGH;
            PH_HIGH: if (expire) phase_d = last_pulse ? PH_STOP : PH_LOW;
            PH_STOP: phase_d = PH_DONE;
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    // Output decode from the registered phase.
    always_comb begin
        scl_low_o    = (phase_q == PH_LOW);
        nack_force_o = tick_run || (phase_q == PH_STOP);
        stop_req_o   = (phase_q == PH_STOP);
        done_o       = (phase_q == PH_DONE);
        busy_o       = (phase_q != PH_IDLE);
    end
endmodule

// File: rtl/i2c_bus_clear_chk.sv
// Port-level checker for the bus-clear sequencer, bound to its top module.
module i2c_bus_clear_chk #(
    parameter int NUM_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_low_o,
    input logic nack_force_o,
    input logic stop_req_o,
    input logic done_o,
    input logic busy_o,
    input logic timeout_o
);
    logic        scl_prev;
    logic [7:0]  seen;

    // Count SCL low-going edges within an attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) begin
            seen     <= '0;
            scl_prev <= 1'b0;
        end else begin
            scl_prev <= scl_low_o;
            if (scl_low_o && !scl_prev)
                seen <= seen + 8'd1;
        end
    end

    // R3
    scl_needs_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_low_o |-> nack_force_o && busy_o);
    // R2
    lead_in_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> nack_force_o && !scl_low_o);
    // R3
    pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req_o |-> (seen == 8'(NUM_PULSES)) && !scl_low_o);
    // R5
    done_follows_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req_o |=> done_o && !stop_req_o);
    // R5
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o && !scl_low_o && !nack_force_o);
    // R4
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stop_req_o, done_o}));
    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o && !$rose(nack_force_o));
    // R8
    timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !busy_o);
endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(.NUM_PULSES(NUM_PULSES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_low_o(scl_low_o),
    .nack_force_o(nack_force_o), .stop_req_o(stop_req_o), .done_o(done_o),
    .busy_o(busy_o), .timeout_o(timeout_o)
);

// File: tb/test_i2c_bus_clear.sv
module test_i2c_bus_clear;
    localparam int TW = 16;
    localparam int NP = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          bus_free_i = 1'b0;
    logic [TW-1:0] half_ticks_i = '0;
    logic scl_low_o, nack_force_o, stop_req_o, done_o, busy_o, timeout_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    i2c_bus_clear #(.TICK_W(TW), .NUM_PULSES(NP), .MAX_TRIES(2)) i_i2c_bus_clear (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_free_i(bus_free_i),
        .half_ticks_i(half_ticks_i), .scl_low_o(scl_low_o),
        .nack_force_o(nack_force_o), .stop_req_o(stop_req_o), .done_o(done_o),
        .busy_o(busy_o), .timeout_o(timeout_o)
    );

    function automatic logic [5:0] outs();
        return {scl_low_o, nack_force_o, stop_req_o, done_o, busy_o, timeout_o};
    endfunction

    // Expected {scl,nack,stop,done,busy,timeout} in cycle i after acceptance.
    function automatic logic [5:0] expect_at(int i, int h);
        int span = (2 * NP + 1) * h;
        if (i < h)        return 6'b010010;
        if (i < span)     return (((i - h) / h) % 2 == 0) ? 6'b110010 : 6'b010010;
        if (i == span)    return 6'b011010;
        if (i == span + 1) return 6'b000110;
        return 6'b000000;
    endfunction

    task automatic check(string req, logic [5:0] got, logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // One full attempt; with noise, half_ticks and start toggle mid-run.
    task automatic run_seq(int h, bit noise, string req);
        int he = (h == 0) ? 1 : h;
        int span = (2 * NP + 1) * he;
        int bad = 0;
        half_ticks_i = TW'(h);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i <= span + 2; i++) begin
            if (outs() !== expect_at(i, he)) begin
                if (bad == 0)
                    $display("FAIL %s: cycle %0d h=%0d got %b expected %b",
                             req, i, he, outs(), expect_at(i, he));
                bad++;
            end
            if (noise) begin
                half_ticks_i = TW'($urandom_range(0, 12));
                start_i = (i <= span) ? ($urandom_range(0, 3) == 0) : 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic free_bus();
        bus_free_i = 1'b1;
        @(negedge clk);
        bus_free_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7431));
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        check("R1", outs(), 6'b000000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 6'b000000);

        // R2 R3 R4 R5: plain attempt with H=1
        run_seq(1, 1'b0, "R2/R3/R4/R5 h=1");
        // R6 R7: H=3 with changing half_ticks and stray starts
        run_seq(3, 1'b1, "R6/R7 h=3 noisy");

        // R8: two attempts granted, third refused
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 refused start", outs(), 6'b000001);
        repeat (4) @(negedge clk);
        check("R8 still idle", outs(), 6'b000001);

        // R9: bus free clears timeout and allows a new attempt
        free_bus();
        check("R9 timeout cleared", outs(), 6'b000000);
        run_seq(0, 1'b0, "R2 h=0 as 1");
        run_seq(2, 1'b0, "R9 second grant");
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 limit again", outs(), 6'b000001);

        // Random lengths and noise
        for (int k = 0; k < 8; k++) begin
            free_bus();
            run_seq($urandom_range(1, 7), k[0], "R3/R6 random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule